// File: doc/BRIEF.md
# Three-Phase Underlap Insertion with Emergency Shutdown

This block turns one PWM level per inverter leg into a pair of switch drives: a high-side drive that follows the level and a low-side drive that follows its inverse. Each drive turns on only after the level has been stable for a programmable number of timebase ticks, and it turns off on the next clock. Across every transition both drives of a leg are therefore off for the programmed underlap interval. A level pulse shorter than that interval never reaches the switch it would have turned on.

A single shutdown latch serves all legs. A high shutdown request, sampled on the master clock, latches the tripped state and drops every drive. Only a reset cycle clears the latch, and only when the request is low on the first clock after reset is released. A separate active-low inhibit forces the drives off while the underlap timing keeps running, so the outputs resume on the very cycle the inhibit is lifted. While reset is held low, every drive is off and the status output reads tripped.

Top module: `deadtime_trip_gate`

## Requirements
- R1: Each leg's high-side drive is on only when the PWM level sampled on the previous clock was 1, and the low-side drive only when it was 0. The two drives of a leg are never on together.
- R2: A drive turns on once `64 - delay_code` ticks have been counted since the clock that captured the level change. Code 63 gives 1 tick, code 62 gives 2 ticks and code 0 gives 64 ticks.
- R3: On the clock edge that captures a change of a leg's PWM level, both drives of that leg are off after that edge. Turn-off is never delayed.
- R4: If a level lasts fewer ticks than the delay, it produces no pulse on the drive it belongs to.
- R5: The delay counter advances only on clocks where `tick` is high. With `tick` held low, a pending turn-on waits indefinitely.
- R6: If `set_trip` is high at a clock edge, then after that edge `trip_n` is 0 and all drives are off.
- R7: Once tripped, the block stays tripped until a reset cycle. The trip clears on the first clock after `rst_n` returns high, but only if `set_trip` is low on that clock. Otherwise it stays tripped until the next reset cycle. `trip_n` is 1 when the block is not tripped.
- R8: While `rst_n` is low, all drives are off and `trip_n` is 0. The level register and the counters are cleared, with the level cleared to 0.
- R9: While `inhibit_n` is 0, all drives are off, but the level tracking and the delay counting continue. When `inhibit_n` returns to 1, any drive whose delay has already elapsed turns on immediately, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| tick | input | 1 | Timebase enable for the underlap counters |
| pwm_in | input | NPH | Filtered PWM level per leg |
| delay_code | input | CODE_W | Inverted underlap code; delay = 2^CODE_W - code ticks |
| set_trip | input | 1 | Emergency shutdown request, active high |
| inhibit_n | input | 1 | Output inhibit, active low |
| drv_hi | output | NPH | High-side switch drive per leg |
| drv_lo | output | NPH | Low-side switch drive per leg |
| trip_n | output | 1 | Shutdown status, 0 while tripped |

## Verification
Several functions can act on the same clock, and the bench stresses two of these overlaps.

The first is the clock on which reset is released. The trip-clear decision and a new shutdown request meet on that clock. The bench releases reset with `set_trip` both high and low, and checks that the latch stays set in the first case and clears in the second.

The second overlap is between inhibit release and an underlap interval that has just expired. The bench lifts the inhibit while a turn-on is still pending, and also after it has matured. Random stimulus toggles the inhibit, the shutdown request and the PWM levels independently, so these events also coincide at random. A cycle model in the bench predicts every output.

// File: rtl/deadtime_trip_gate.sv
module deadtime_trip_gate #(
  parameter int NPH    = 3,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NPH-1:0]    pwm_in,
  input  logic [CODE_W-1:0] delay_code,
  input  logic              set_trip,
  input  logic              inhibit_n,
  output logic [NPH-1:0]    drv_hi,
  output logic [NPH-1:0]    drv_lo,
  output logic              trip_n
);

  localparam int CNT_W = CODE_W + 1;
  localparam logic [CNT_W-1:0] SPAN = CNT_W'(1) << CODE_W;

  logic [CNT_W-1:0] pdy;
  logic             tripped;
  logic             armed;
  logic             gate;

  assign pdy    = SPAN - {1'b0, delay_code};
  assign gate   = rst_n & ~tripped & inhibit_n;
  assign trip_n = ~tripped;

  // Shutdown latch: forced set in reset, cleared once on the first clock after release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tripped <= 1'b1;
      armed   <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (set_trip)    tripped <= 1'b1;
      else if (!armed) tripped <= 1'b0;
    end
  end

  // R6
  trip_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_trip |=> (!trip_n && drv_hi == '0 && drv_lo == '0));

  // R7
  trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip_n && armed) |=> !trip_n);

  for (genvar i = 0; i < NPH; i++) begin : g_leg
    logic             lvl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             settled;

    assign settled = (cnt_q >= pdy);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q <= 1'b0;
        cnt_q <= '0;
      end else if (pwm_in[i] != lvl_q) begin
        lvl_q <= pwm_in[i];
        cnt_q <= '0;
      end else if (tick && !settled) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

    assign drv_hi[i] = gate &  lvl_q & settled;
    assign drv_lo[i] = gate & ~lvl_q & settled;

    // R1
    hi_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_hi[i] |-> $past(pwm_in[i]));

    // R1
    lo_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_lo[i] |-> !$past(pwm_in[i]));

    // R3
    fall_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_in[i] != lvl_q) |=> (!drv_hi[i] && !drv_lo[i]));
  end

endmodule

// File: tb/deadtime_trip_gate_bench.sv
module deadtime_trip_gate_bench;
  localparam int NPH = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n = 1'b0;
  logic           tick = 1'b0;
  logic [NPH-1:0] pwm_in = '0;
  logic [5:0]     delay_code = 6'd63;
  logic           set_trip = 1'b0;
  logic           inhibit_n = 1'b1;
  logic [NPH-1:0] drv_hi, drv_lo;
  logic           trip_n;

  deadtime_trip_gate u_deadtime_trip_gate (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwm_in(pwm_in),
    .delay_code(delay_code), .set_trip(set_trip), .inhibit_n(inhibit_n),
    .drv_hi(drv_hi), .drv_lo(drv_lo), .trip_n(trip_n)
  );

  int nvec = 0;
  int nerr = 0;
  int m_lvl[NPH];
  int m_cnt[NPH];
  bit m_trip = 1'b1;
  bit m_armed = 1'b0;

  function automatic int pdy_of(logic [5:0] c);
    return 64 - int'(c);
  endfunction

  task automatic model_edge();
    if (!rst_n) begin
      m_trip = 1'b1;
      m_armed = 1'b0;
      for (int i = 0; i < NPH; i++) begin m_lvl[i] = 0; m_cnt[i] = 0; end
    end else begin
      if (set_trip) m_trip = 1'b1;
      else if (!m_armed) m_trip = 1'b0;
      m_armed = 1'b1;
      for (int i = 0; i < NPH; i++) begin
        if (int'(pwm_in[i]) != m_lvl[i]) begin
          m_lvl[i] = int'(pwm_in[i]);
          m_cnt[i] = 0;
        end else if (tick && m_cnt[i] < pdy_of(delay_code)) begin
          m_cnt[i]++;
        end
      end
    end
  endtask

  function automatic logic [NPH-1:0] exp_drv(bit hi_side);
    logic [NPH-1:0] v;
    for (int i = 0; i < NPH; i++)
      v[i] = rst_n && !m_trip && inhibit_n && (m_cnt[i] >= pdy_of(delay_code)) &&
             (hi_side ? (m_lvl[i] == 1) : (m_lvl[i] == 0));
    return v;
  endfunction

  task automatic check(string tag, logic [NPH:0] act, logic [NPH:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check({tag, " hi"}, {1'b0, drv_hi}, {1'b0, exp_drv(1'b1)});
    check({tag, " lo"}, {1'b0, drv_lo}, {1'b0, exp_drv(1'b0)});
    check({tag, " trip_n"}, {3'b0, trip_n}, {3'b0, !m_trip});
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1337));
    @(negedge clk);
    // R8 reset state
    step("R8 reset");
    check("R8 reset drives", {1'b0, drv_hi | drv_lo}, '0);
    check("R8 reset trip_n", {3'b0, trip_n}, '0);

    // R7 release with set_trip low clears trip
    rst_n = 1'b1;
    step("R7 release");
    check("R7 cleared", {3'b0, trip_n}, {3'b0, 1'b1});

    // R2 code 63 -> 1 tick; R3 low side drops on capture clock
    tick = 1'b1; delay_code = 6'd63;
    repeat (2) step("R2 settle");
    check("R2 lo on", {1'b0, drv_lo}, {1'b0, 3'b111});
    pwm_in = 3'b111;
    step("R3 capture");
    check("R3 both off", {1'b0, drv_hi | drv_lo}, '0);
    step("R2 pdy1");
    check("R2 pdy1 hi", {1'b0, drv_hi}, {1'b0, 3'b111});

    // R2 code 0 -> 64 ticks
    delay_code = 6'd0; pwm_in = 3'b000;
    repeat (64) step("R2 pdy64");
    check("R2 pdy64 early", {1'b0, drv_lo}, '0);
    step("R2 pdy64");
    check("R2 pdy64 on", {1'b0, drv_lo}, {1'b0, 3'b111});

    // R5 tick gating
    delay_code = 6'd62; pwm_in = 3'b111; tick = 1'b0;
    repeat (11) step("R5 hold");
    check("R5 no tick", {1'b0, drv_hi}, '0);
    tick = 1'b1;
    step("R5 t1");
    check("R5 one tick", {1'b0, drv_hi}, '0);
    step("R5 t2");
    check("R5 two ticks", {1'b0, drv_hi}, {1'b0, 3'b111});

    // R4 short pulse on low side (pdy 2)
    pwm_in = 3'b000; step("R4 a");
    pwm_in = 3'b111; step("R4 b");
    check("R4 short lo", {1'b0, drv_lo}, '0);
    repeat (3) step("R4 c");
    check("R4 no lo pulse", {1'b0, drv_lo}, '0);

    // R9 inhibit keeps timing running
    inhibit_n = 1'b0;
    step("R9 inh");
    check("R9 inhibited", {1'b0, drv_hi | drv_lo}, '0);
    pwm_in = 3'b000;
    repeat (5) step("R9 inh run");
    inhibit_n = 1'b1;
    #1;
    check("R9 resume now", {1'b0, drv_lo}, {1'b0, 3'b111});
    pwm_in = 3'b111; inhibit_n = 1'b0; step("R9 pend");
    inhibit_n = 1'b1; step("R9 pend rel");
    check("R9 pending", {1'b0, drv_hi}, '0);
    step("R9 mature");
    check("R9 matured", {1'b0, drv_hi}, {1'b0, 3'b111});

    // R6 / R7 shutdown and reset-release coincidence
    set_trip = 1'b1; step("R6 trip");
    check("R6 tripped", {1'b0, drv_hi | drv_lo}, '0);
    check("R6 trip_n", {3'b0, trip_n}, '0);
    set_trip = 1'b0;
    repeat (5) step("R7 hold");
    check("R7 latched", {3'b0, trip_n}, '0);
    rst_n = 1'b0; set_trip = 1'b1; step("R7 rst");
    rst_n = 1'b1; step("R7 rel high");
    set_trip = 1'b0; step("R7 after");
    check("R7 still tripped", {3'b0, trip_n}, '0);
    rst_n = 1'b0; step("R7 rst2");
    rst_n = 1'b1; step("R7 rel low");
    check("R7 clear", {3'b0, trip_n}, {3'b0, 1'b1});

    // Random phase
    for (int n = 0; n < 6000; n++) begin
      if (n % 400 == 0) begin
        case ($urandom % 5)
          0: delay_code = 6'd63;
          1: delay_code = 6'd61;
          2: delay_code = 6'd56;
          3: delay_code = 6'($urandom);
          default: delay_code = 6'd0;
        endcase
      end
      for (int i = 0; i < NPH; i++)
        if ($urandom % 10 == 0) pwm_in[i] = ~pwm_in[i];
      tick = ($urandom % 3) != 0;
      if ($urandom % 40 == 0) inhibit_n = ~inhibit_n;
      set_trip = ($urandom % 700 == 0);
      if (!rst_n) begin
        rst_n = 1'b1;
        set_trip = ($urandom % 2 == 0);
      end else if (m_trip && ($urandom % 30 == 0)) begin
        rst_n = 1'b0;
      end
      step("R1 random");
    end

    summary();
    $finish;
  end
endmodule